// File: doc/BRIEF.md
# DMA Channel Attribute Register Bank

This block is the software-visible register file of a 32-channel DMA controller. Each per-channel attribute (channel enable, peripheral request mask, burst-only mode, alternate control structure select, high priority and secondary source assignment) is kept as one flop per channel. Software changes an attribute through two addresses: a write-one-to-set word and a write-one-to-clear word. Because of this split, no read-modify-write is needed, and two pieces of software can update different channels without racing each other.

The block also holds the controller-wide enable, a read-only status word, the channel control table base pointer and an alternate base derived from it. It also holds the software request bits, a sticky bus-error flag, the per-channel completion interrupt status and the 4-bit source-select map fields. The transfer engine sits outside this block. It drives one-hot-per-channel event vectors that update the attribute bits on their own: completion, bus error, software request served, tail shorter than a burst, and alternate switch. It also receives the stored attributes as plain output vectors. The bus port is single-cycle: a write takes effect at the clock edge where `bus_wr` is high, and `bus_rdata` is a combinational function of `bus_addr` and the current state.

Top module: `dma_chan_regs`

## Requirements
- R1: Each attribute has a set word and a clear word at these byte offsets: enable 0x20/0x24, request mask 0x28/0x2C, burst-only 0x30/0x34, alternate select 0x38/0x3C, high priority 0x40/0x44, secondary assignment 0x48/0x4C. A 1 in data bit n at the set word sets channel n's bit, and a 1 at the clear word clears it. Zero data bits leave the channel's bit unchanged. Reading the set word returns the bit vector, and reading the clear word returns zero. The vectors also appear on the matching output ports.
- R2: Writing 1s to the software request word (0x14) sets those request bits, and reading 0x14 returns them. A bit clears when `eng_swdone` reports that channel.
- R3: A channel flagged on `eng_done` has its enable bit cleared and its completion interrupt status bit set at the next edge.
- R4: A channel flagged on `eng_err` has its enable bit cleared and sets the error flag (bit 0 of offset 0x18). Enable bits of other channels and the interrupt status are unaffected. Writing 1 to bit 0 of 0x18 clears the flag, and writing 0 leaves it set.
- R5: The completion interrupt status (offset 0x1C) clears bit by bit when 1s are written to it, and zero bits written leave it unchanged.
- R6: The control base (0x08) stores only bits 31:10, so it reads back with bits 9:0 zero. The alternate base (0x0C, read-only) reads as the control base plus 0x200.
- R7: Bit 0 of the configuration word (0x04) is the master enable. The status word (0x00) holds channel count minus one in bits 20:16, `eng_state` in bits 7:4 and the master enable in bit 0, with all other bits zero. For 32 channels it reads 0x001F0000 plus the state and enable fields.
- R8: While the master enable is 0, reads of status (0x00), control base, alternate base and wait status (0x10) return zero. The stored values and output ports are kept.
- R9: A channel flagged on `eng_burst_tail` has its burst-only bit cleared.
- R10: A channel flagged on `eng_alt_set` has its alternate select bit set.
- R11: The map words at 0x50, 0x54, 0x58 and 0x5C hold eight 4-bit fields each. Channel n's field is in word n/8 at bits 4*(n%8)+3:4*(n%8), and it is driven on `src_map[4n+3:4n]`. The words read back as written.
- R12: When a hardware event and a software write touch the same bit in the same cycle, the hardware event wins. This applies to enable, burst-only, software request, alternate select, interrupt status and the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| eng_state | input | 4 | Engine state code reported in status |
| eng_wait | input | NCH | Per-channel wait-on-request status |
| eng_done | input | NCH | Channel finished its DMA cycle |
| eng_err | input | NCH | Bus error on channel |
| eng_swdone | input | NCH | Software request served |
| eng_burst_tail | input | NCH | Fewer items remain than the burst size |
| eng_alt_set | input | NCH | Engine switched channel to alternate structure |
| master_en | output | 1 | Controller-wide enable |
| chan_en | output | NCH | Channel enables |
| req_mask | output | NCH | Peripheral request masks |
| burst_only | output | NCH | Burst-only mode per channel |
| alt_sel | output | NCH | Alternate structure select |
| hi_prio | output | NCH | High priority per channel |
| sec_asgn | output | NCH | Secondary assignment per channel |
| sw_req | output | NCH | Pending software requests |
| irq_stat | output | NCH | Completion interrupt status |
| err_flag | output | 1 | Sticky bus-error flag |
| ctl_base | output | 32 | Control table base, bits 9:0 zero |
| src_map | output | 4*NCH | Per-channel source-select fields |

## Verification
The assertions assume that the event vectors hold only the channels the engine is acting on in that cycle. They also assume that a write to the enable set word is checked only in cycles with no completion or error event, since R12 governs those cycles. The stimulus pulses each event for exactly one cycle from a negative edge and keeps the bus idle except during the write under test. The R12 cases deliberately align a bus write with an event on the same bit, and no other check relies on both happening at once.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int          NCH     = 32,
  parameter int          AW      = 8,
  parameter logic [31:0] ALT_OFS = 32'h200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [3:0]       eng_state,
  input  logic [NCH-1:0]   eng_wait,
  input  logic [NCH-1:0]   eng_done,
  input  logic [NCH-1:0]   eng_err,
  input  logic [NCH-1:0]   eng_swdone,
  input  logic [NCH-1:0]   eng_burst_tail,
  input  logic [NCH-1:0]   eng_alt_set,
  output logic             master_en,
  output logic [NCH-1:0]   chan_en,
  output logic [NCH-1:0]   req_mask,
  output logic [NCH-1:0]   burst_only,
  output logic [NCH-1:0]   alt_sel,
  output logic [NCH-1:0]   hi_prio,
  output logic [NCH-1:0]   sec_asgn,
  output logic [NCH-1:0]   sw_req,
  output logic [NCH-1:0]   irq_stat,
  output logic             err_flag,
  output logic [31:0]      ctl_base,
  output logic [4*NCH-1:0] src_map
);

  localparam int NMW = (NCH + 7) / 8;
  localparam logic [4:0] CH_M1 = 5'(NCH - 1);

  localparam logic [AW-1:0] A_STAT  = AW'('h00);
  localparam logic [AW-1:0] A_CFG   = AW'('h04);
  localparam logic [AW-1:0] A_CTL   = AW'('h08);
  localparam logic [AW-1:0] A_ALTB  = AW'('h0C);
  localparam logic [AW-1:0] A_WAIT  = AW'('h10);
  localparam logic [AW-1:0] A_SWREQ = AW'('h14);
  localparam logic [AW-1:0] A_ERR   = AW'('h18);
  localparam logic [AW-1:0] A_IRQ   = AW'('h1C);
  localparam logic [AW-1:0] A_ENS   = AW'('h20);
  localparam logic [AW-1:0] A_ENC   = AW'('h24);
  localparam logic [AW-1:0] A_MSKS  = AW'('h28);
  localparam logic [AW-1:0] A_MSKC  = AW'('h2C);
  localparam logic [AW-1:0] A_BRS   = AW'('h30);
  localparam logic [AW-1:0] A_BRC   = AW'('h34);
  localparam logic [AW-1:0] A_ALS   = AW'('h38);
  localparam logic [AW-1:0] A_ALC   = AW'('h3C);
  localparam logic [AW-1:0] A_PRS   = AW'('h40);
  localparam logic [AW-1:0] A_PRC   = AW'('h44);
  localparam logic [AW-1:0] A_ASS   = AW'('h48);
  localparam logic [AW-1:0] A_ASC   = AW'('h4C);
  localparam logic [AW-1:0] A_MAP   = AW'('h50);

  logic [NCH-1:0]    wd;
  logic [21:0]       base_q;
  logic [NMW*32-1:0] map_q;
  logic [NCH-1:0]    none;

  assign wd   = bus_wdata[NCH-1:0];
  assign none = '0;

  function automatic logic [NCH-1:0] wsel(input logic hit, input logic [NCH-1:0] d);
    return hit ? d : '0;
  endfunction

  // hardware set and clear are applied after software, so hardware wins
  function automatic logic [NCH-1:0] nxt(input logic [NCH-1:0] q, sws, swc, hws, hwc);
    return (((q | sws) & ~swc) & ~hwc) | hws;
  endfunction

  function automatic logic [31:0] ext(input logic [NCH-1:0] v);
    logic [31:0] r;
    r = '0;
    r[NCH-1:0] = v;
    return r;
  endfunction

  logic w_ens, w_enc, w_msks, w_mskc, w_brs, w_brc, w_als, w_alc;
  logic w_prs, w_prc, w_ass, w_asc, w_sw, w_irq, w_err, w_cfg, w_ctl;

  assign w_ens  = bus_wr && bus_addr == A_ENS;
  assign w_enc  = bus_wr && bus_addr == A_ENC;
  assign w_msks = bus_wr && bus_addr == A_MSKS;
  assign w_mskc = bus_wr && bus_addr == A_MSKC;
  assign w_brs  = bus_wr && bus_addr == A_BRS;
  assign w_brc  = bus_wr && bus_addr == A_BRC;
  assign w_als  = bus_wr && bus_addr == A_ALS;
  assign w_alc  = bus_wr && bus_addr == A_ALC;
  assign w_prs  = bus_wr && bus_addr == A_PRS;
  assign w_prc  = bus_wr && bus_addr == A_PRC;
  assign w_ass  = bus_wr && bus_addr == A_ASS;
  assign w_asc  = bus_wr && bus_addr == A_ASC;
  assign w_sw   = bus_wr && bus_addr == A_SWREQ;
  assign w_irq  = bus_wr && bus_addr == A_IRQ;
  assign w_err  = bus_wr && bus_addr == A_ERR;
  assign w_cfg  = bus_wr && bus_addr == A_CFG;
  assign w_ctl  = bus_wr && bus_addr == A_CTL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en    <= '0;
      req_mask   <= '0;
      burst_only <= '0;
      alt_sel    <= '0;
      hi_prio    <= '0;
      sec_asgn   <= '0;
      sw_req     <= '0;
      irq_stat   <= '0;
      err_flag   <= 1'b0;
      master_en  <= 1'b0;
      base_q     <= '0;
    end else begin
      chan_en    <= nxt(chan_en, wsel(w_ens, wd), wsel(w_enc, wd), none, eng_done | eng_err);
      req_mask   <= nxt(req_mask, wsel(w_msks, wd), wsel(w_mskc, wd), none, none);
      burst_only <= nxt(burst_only, wsel(w_brs, wd), wsel(w_brc, wd), none, eng_burst_tail);
      alt_sel    <= nxt(alt_sel, wsel(w_als, wd), wsel(w_alc, wd), eng_alt_set, none);
      hi_prio    <= nxt(hi_prio, wsel(w_prs, wd), wsel(w_prc, wd), none, none);
      sec_asgn   <= nxt(sec_asgn, wsel(w_ass, wd), wsel(w_asc, wd), none, none);
      sw_req     <= nxt(sw_req, wsel(w_sw, wd), none, none, eng_swdone);
      irq_stat   <= nxt(irq_stat, none, wsel(w_irq, wd), eng_done, none);
      err_flag   <= (|eng_err) | (err_flag & ~(w_err & bus_wdata[0]));
      if (w_cfg) master_en <= bus_wdata[0];
      if (w_ctl) base_q <= bus_wdata[31:10];
    end
  end

  for (genvar w = 0; w < NMW; w++) begin : g_map
    localparam logic [AW-1:0] AM = A_MAP + AW'(4 * w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map_q[32*w +: 32] <= '0;
      else if (bus_wr && bus_addr == AM) map_q[32*w +: 32] <= bus_wdata;
    end
  end

  assign ctl_base = {base_q, 10'b0};
  assign src_map  = map_q[4*NCH-1:0];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT:  bus_rdata = master_en ? {11'b0, CH_M1, 8'b0, eng_state, 3'b0, 1'b1} : '0;
      A_CFG:   bus_rdata = {31'b0, master_en};
      A_CTL:   bus_rdata = master_en ? ctl_base : '0;
      A_ALTB:  bus_rdata = master_en ? ctl_base + ALT_OFS : '0;
      A_WAIT:  bus_rdata = master_en ? ext(eng_wait) : '0;
      A_SWREQ: bus_rdata = ext(sw_req);
      A_ERR:   bus_rdata = {31'b0, err_flag};
      A_IRQ:   bus_rdata = ext(irq_stat);
      A_ENS:   bus_rdata = ext(chan_en);
      A_MSKS:  bus_rdata = ext(req_mask);
      A_BRS:   bus_rdata = ext(burst_only);
      A_ALS:   bus_rdata = ext(alt_sel);
      A_PRS:   bus_rdata = ext(hi_prio);
      A_ASS:   bus_rdata = ext(sec_asgn);
      default: begin
        for (int w = 0; w < NMW; w++)
          if (bus_addr == A_MAP + AW'(4 * w)) bus_rdata = map_q[32*w +: 32];
      end
    endcase
  end

  // R1
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ens && !(|eng_done) && !(|eng_err)) |=> chan_en == ($past(chan_en) | $past(wd)));
  // R2
  swreq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_swdone) |=> (sw_req & $past(eng_swdone)) == '0);
  // R3
  done_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_done) |=> ((chan_en & $past(eng_done)) == '0) && ((irq_stat & $past(eng_done)) == $past(eng_done)));
  // R4
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_err) |=> err_flag && ((chan_en & $past(eng_err)) == '0));
  // R8
  gated_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_en && (bus_addr == A_STAT || bus_addr == A_ALTB)) |-> bus_rdata == '0);
  // R9
  tail_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_burst_tail) |=> (burst_only & $past(eng_burst_tail)) == '0);
  // R10
  alt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_alt_set) |=> (alt_sel & $past(eng_alt_set)) == $past(eng_alt_set));

endmodule

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  localparam int CLK_NS = 10;
  localparam int NCH = 32;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] eng_state = '0;
  logic [NCH-1:0] eng_wait = '0, eng_done = '0, eng_err = '0, eng_swdone = '0;
  logic [NCH-1:0] eng_burst_tail = '0, eng_alt_set = '0;
  logic master_en, err_flag;
  logic [NCH-1:0] chan_en, req_mask, burst_only, alt_sel, hi_prio, sec_asgn, sw_req, irq_stat;
  logic [31:0] ctl_base;
  logic [4*NCH-1:0] src_map;
  int nchk = 0, nfail = 0;
  bit done_flag = 0;

  always #(CLK_NS/2) clk = ~clk;

  dma_chan_regs u0 (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .eng_state,
    .eng_wait, .eng_done, .eng_err, .eng_swdone, .eng_burst_tail, .eng_alt_set, .master_en,
    .chan_en, .req_mask, .burst_only, .alt_sel, .hi_prio, .sec_asgn, .sw_req, .irq_stat,
    .err_flag, .ctl_base, .src_map);

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_wr = 0; bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic rdchk(input string rq, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(rq, d, exp);
  endtask

  // optional write in the same cycle as a one-cycle engine event
  task automatic evwr(input logic wen, input logic [7:0] a, input logic [31:0] d,
                      input logic [31:0] dn, er, sd, tl, al);
    @(negedge clk);
    bus_wr = wen; bus_addr = a; bus_wdata = d;
    eng_done = dn; eng_err = er; eng_swdone = sd; eng_burst_tail = tl; eng_alt_set = al;
    @(negedge clk);
    bus_wr = 0; eng_done = '0; eng_err = '0; eng_swdone = '0; eng_burst_tail = '0; eng_alt_set = '0;
  endtask

  task automatic t_reset;
    rdchk("R1 reset enable", 8'h20, 0);
    rdchk("R8 status while disabled", 8'h00, 0);
    chk("R1 reset chan_en port", chan_en, 0);
  endtask

  task automatic t_status;
    eng_state = 4'h5;
    wr(8'h04, 1);
    rdchk("R7 status word", 8'h00, 32'h001F0051);
    rdchk("R7 config readback", 8'h04, 1);
    wr(8'h04, 0);
    rdchk("R8 status gated", 8'h00, 0);
    wr(8'h04, 1);
  endtask

  task automatic t_setclr;
    wr(8'h20, 32'hF0F00001);
    rdchk("R1 enable set", 8'h20, 32'hF0F00001);
    wr(8'h24, 32'h00000001);
    wr(8'h20, 0);
    wr(8'h24, 0);
    rdchk("R1 enable clear and zero writes", 8'h20, 32'hF0F00000);
    chk("R1 chan_en port", chan_en, 32'hF0F00000);
    wr(8'h28, 32'hAAAA5555);
    wr(8'h2C, 32'h0000FFFF);
    rdchk("R1 mask set/clear", 8'h28, 32'hAAAA0000);
    rdchk("R1 clear word reads zero", 8'h2C, 0);
    wr(8'h40, 32'h3);
    chk("R1 hi_prio port", hi_prio, 32'h3);
    wr(8'h48, 32'h80000000);
    wr(8'h4C, 32'h00000000);
    chk("R1 sec_asgn port", sec_asgn, 32'h80000000);
    wr(8'h24, 32'hFFFFFFFF);
    rdchk("R1 enable all cleared", 8'h20, 0);
  endtask

  task automatic t_done;
    wr(8'h20, 32'hFF);
    evwr(0, 8'h00, 0, 32'h1, 0, 0, 0, 0);
    rdchk("R3 done clears enable", 8'h20, 32'hFE);
    rdchk("R3 done sets irq", 8'h1C, 32'h1);
    wr(8'h1C, 0);
    rdchk("R5 irq zero write", 8'h1C, 32'h1);
    wr(8'h1C, 1);
    rdchk("R5 irq w1c", 8'h1C, 0);
  endtask

  task automatic t_err;
    evwr(0, 8'h00, 0, 0, 32'h2, 0, 0, 0);
    rdchk("R4 error clears only its channel", 8'h20, 32'hFC);
    rdchk("R4 error flag set", 8'h18, 1);
    rdchk("R4 irq untouched by error", 8'h1C, 0);
    wr(8'h18, 0);
    rdchk("R4 flag kept on zero write", 8'h18, 1);
    wr(8'h18, 1);
    rdchk("R4 flag w1c", 8'h18, 0);
    chk("R4 err_flag port", {31'b0, err_flag}, 0);
  endtask

  task automatic t_base;
    wr(8'h08, 32'h12345678);
    rdchk("R6 base aligned", 8'h08, 32'h12345400);
    rdchk("R6 alternate base", 8'h0C, 32'h12345600);
    eng_wait = 32'hDEADBEEF;
    rdchk("R8 wait visible when enabled", 8'h10, 32'hDEADBEEF);
    wr(8'h04, 0);
    rdchk("R8 base gated", 8'h08, 0);
    rdchk("R8 alt base gated", 8'h0C, 0);
    rdchk("R8 wait gated", 8'h10, 0);
    chk("R8 base kept", ctl_base, 32'h12345400);
    wr(8'h04, 1);
    rdchk("R8 base back", 8'h08, 32'h12345400);
  endtask

  task automatic t_swreq;
    wr(8'h14, 32'h30);
    rdchk("R2 swreq set", 8'h14, 32'h30);
    evwr(0, 8'h00, 0, 0, 0, 32'h10, 0, 0);
    rdchk("R2 swreq served", 8'h14, 32'h20);
    chk("R2 sw_req port", sw_req, 32'h20);
  endtask

  task automatic t_burst;
    wr(8'h30, 32'hF);
    evwr(0, 8'h00, 0, 0, 0, 0, 32'h4, 0);
    rdchk("R9 tail clears burst-only", 8'h30, 32'hB);
  endtask

  task automatic t_alt;
    evwr(0, 8'h00, 0, 0, 0, 0, 0, 32'h80);
    rdchk("R10 engine sets alternate", 8'h38, 32'h80);
    wr(8'h3C, 32'h80);
    rdchk("R10 software clears alternate", 8'h38, 0);
  endtask

  task automatic t_map;
    wr(8'h58, 32'h76543210);
    chk("R11 channel 23 field", {28'b0, src_map[4*23 +: 4]}, 7);
    chk("R11 channel 16 field", {28'b0, src_map[4*16 +: 4]}, 0);
    chk("R11 channel 17 field", {28'b0, src_map[4*17 +: 4]}, 1);
    wr(8'h50, 32'h000000A0);
    chk("R11 channel 1 field", {28'b0, src_map[7:4]}, 32'hA);
    rdchk("R11 map readback", 8'h58, 32'h76543210);
  endtask

  task automatic t_race;
    wr(8'h38, 0);
    evwr(1, 8'h3C, 32'h80, 0, 0, 0, 0, 32'h80);
    rdchk("R12 alt set beats clear", 8'h38, 32'h80);
    evwr(1, 8'h20, 32'h100, 32'h100, 0, 0, 0, 0);
    rdchk("R12 done beats enable set", 8'h20, 32'hFC);
    evwr(1, 8'h1C, 32'h100, 32'h100, 0, 0, 0, 0);
    rdchk("R12 new irq beats w1c", 8'h1C, 32'h100);
    evwr(1, 8'h30, 32'h1, 0, 0, 0, 32'h1, 0);
    rdchk("R12 tail beats burst set", 8'h30, 32'hA);
    evwr(1, 8'h18, 32'h1, 0, 32'h4, 0, 0, 0);
    rdchk("R12 error beats flag clear", 8'h18, 1);
    rdchk("R12 error cleared enable", 8'h20, 32'hF8);
    evwr(1, 8'h14, 32'h1, 0, 0, 32'h1, 0, 0);
    rdchk("R12 served beats swreq set", 8'h14, 32'h20);
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done_flag) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_status();
    t_setclr();
    t_done();
    t_err();
    t_base();
    t_swreq();
    t_burst();
    t_alt();
    t_map();
    t_race();
    done_flag = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule